// File: doc/BRIEF.md
# Memory Test Access Port with Boundary Ring

This block is the test access logic of a memory device. It reads a four-wire serial test port (TCK, TMS, TDI, TDO) through a standard sixteen-state controller. A 3-bit instruction register holds the current opcode. Three data paths can be placed between TDI and TDO: a 1-bit bypass stage, a 32-bit identification word and a 109-bit boundary ring.

The opcode map is not the common one. All-zeros selects the external-test instruction. A dedicated opcode samples the ring and also forces every functional output driver to high impedance. Three codes are reserved and are handled safely.

The parallel side of the ring is made of plain ports. One vector carries the captured pin states in. Another carries the preload latches out. A flag reports that the external-test instruction is active, and a second flag asks the pads to float. The pads, the core and the order of the ring cells lie outside this block. The reset input is active low and is sampled on the rising edge of TCK.

Top module: `bscan_tap_top`

## Requirements
- R1: The controller follows the standard sixteen-state sequence on rising TCK edges. Five consecutive rising edges with TMS high bring it to Test-Logic-Reset from any state.
- R2: While the controller is in Test-Logic-Reset, or while `trst_n` is low, the active instruction becomes IDCODE (001) and `outputs_hiz` and `ext_drive` are low.
- R3: In Capture-IR the instruction shift stage loads 001. It then shifts LSB first, with TDI entering at bit 2. The shifted value becomes active only on the rising edge taken in Update-IR, so `outputs_hiz` keeps the old instruction's value during Shift-IR.
- R4: IDCODE (001) selects the 32-bit identification path. Capture-DR loads revision in [31:29] (default 000), device type in [28:12], vendor code in [11:1], and 1 in bit 0.
- R5: BYPASS (111) selects a 1-bit stage that captures 0. It delays TDI by one shift cycle.
- R6: The reserved codes 011, 101 and 110 behave exactly like BYPASS and never raise `outputs_hiz` or `ext_drive`.
- R7: SAMPLE Z (010) selects the 109-bit ring and captures `ring_capture` in Capture-DR. It drives `outputs_hiz` high for as long as it is the active instruction.
- R8: SAMPLE/PRELOAD (100) selects the ring and captures `ring_capture`. Update-DR copies the shifted ring contents to `ring_preload`. `outputs_hiz` stays low.
- R9: EXTEST (000) selects the ring, captures `ring_capture` and raises `ext_drive` while active. `outputs_hiz` stays low.
- R10: TDO changes only on falling TCK edges and presents the selected register's bit 0. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR.
- R11: `ring_preload` changes only on an Update-DR edge under an instruction that selects the ring. It resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low reset, sampled on rising TCK |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| ring_capture | input | 109 | Parallel pin states captured into the ring |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while shifting; the TDO driver is enabled |
| ring_preload | output | 109 | Ring update latches |
| outputs_hiz | output | 1 | Force all functional output drivers to high impedance |
| ext_drive | output | 1 | External-test instruction active; pads take `ring_preload` |

## Verification
The hardest case to reach is a change of instruction observed at the exact edge where it happens. A new opcode is partly shifted in while the old one still controls `outputs_hiz`. The stimulus first loads SAMPLE Z and then shifts in SAMPLE/PRELOAD. It samples the high-impedance flag in the middle of Shift-IR, where it must still be high, and again after Update-IR, where it must have dropped. A TMS-only walk out of Run-Test-Idle checks that Test-Logic-Reset clears the flag without the reset pin.

// File: rtl/bscan_pkg.sv
// Package bscan_pkg
// Shared types and opcode constants for the test access port.
// Assumes a fixed 3-bit opcode map. The data path widths are parameters of the modules.
package bscan_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_ID,
        PATH_BSR
    } dr_path_t;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/bscan_fsm.sv
// Module bscan_fsm
// Sixteen-state test port controller, advanced by TMS on rising TCK.
// Assumes trst_n is synchronous to TCK. Reset puts the controller in Test-Logic-Reset.
module bscan_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t state_nxt;

    // Next state from the current state and TMS.
    always_comb begin
        unique case (state)
            ST_TLR:    state_nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    state_nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: state_nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: state_nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: state_nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   state_nxt = ST_TLR;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= state_nxt;
    end

endmodule

// File: rtl/bscan_ir.sv
// Module bscan_ir
// Instruction shift stage and active instruction register.
// Capture loads a fixed pattern. Shifting is LSB first, with TDI entering at the top bit.
// The active value changes only in Update-IR, or returns to IDCODE in Test-Logic-Reset.
module bscan_ir
    import bscan_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic            ir_lsb,
    output logic [IR_W-1:0] ir_active
);

    logic [IR_W-1:0] ir_sh;

    // Shift stage: capture the fixed pattern, or shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ir_sh <= IR_CAPTURE;
        end else if (state == ST_CAP_IR) begin
            ir_sh <= IR_CAPTURE;
        end else if (state == ST_SH_IR) begin
            ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        end
    end

    // Active instruction: IDCODE on reset, shifted value on Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) begin
            ir_active <= OP_IDCODE;
        end else if (state == ST_UPD_IR) begin
            ir_active <= ir_sh;
        end
    end

    assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/bscan_decode.sv
// Module bscan_decode
// Maps the active opcode to a data path and to the two pad controls.
// Assumes unlisted opcodes are reserved. They fall back to bypass with both controls low.
module bscan_decode
    import bscan_pkg::*;
(
    input  logic [IR_W-1:0] ir_active,
    output dr_path_t        dr_path,
    output logic            outputs_hiz,
    output logic            ext_drive
);

    // Opcode decode; the default branch covers the reserved codes.
    always_comb begin
        dr_path     = PATH_BYP;
        outputs_hiz = 1'b0;
        ext_drive   = 1'b0;
        unique case (ir_active)
            OP_EXTEST: begin
                dr_path   = PATH_BSR;
                ext_drive = 1'b1;
            end
            OP_IDCODE:  dr_path = PATH_ID;
            OP_SAMPLEZ: begin
                dr_path     = PATH_BSR;
                outputs_hiz = 1'b1;
            end
            OP_PRELOAD: dr_path = PATH_BSR;
            OP_BYPASS:  dr_path = PATH_BYP;
            default:    dr_path = PATH_BYP;
        endcase
    end

endmodule

// File: rtl/bscan_dr.sv
// Module bscan_dr
// The three data paths: bypass stage, identification word and boundary ring with update latches.
// Only the path chosen by the decoder captures or shifts. The others hold their contents.
module bscan_dr
    import bscan_pkg::*;
#(
    parameter int          BSR_W     = 109,
    parameter logic [2:0]  ID_REV    = 3'b000,
    parameter logic [16:0] ID_PART   = 17'h15A3C,
    parameter logic [10:0] ID_VENDOR = 11'h2B5
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_t       state,
    input  dr_path_t         dr_path,
    input  logic             tdi,
    input  logic [BSR_W-1:0] ring_capture,
    output logic             dr_lsb,
    output logic [BSR_W-1:0] ring_preload
);

    localparam int          ID_W    = 32;
    localparam logic [31:0] ID_WORD = {ID_REV, ID_PART, ID_VENDOR, 1'b1};

    logic             cap_dr, sh_dr, upd_dr;
    logic             byp_q;
    logic [ID_W-1:0]  id_q;
    logic [BSR_W-1:0] bsr_q, bsr_nxt;
    logic             bsr_cap, bsr_sh;

    assign cap_dr  = (state == ST_CAP_DR);
    assign sh_dr   = (state == ST_SH_DR);
    assign upd_dr  = (state == ST_UPD_DR);
    assign bsr_cap = cap_dr && (dr_path == PATH_BSR);
    assign bsr_sh  = sh_dr  && (dr_path == PATH_BSR);

    // Bypass stage: captures zero, then passes TDI through.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (dr_path == PATH_BYP) begin
            if (cap_dr)     byp_q <= 1'b0;
            else if (sh_dr) byp_q <= tdi;
        end
    end

    // Identification word: loads the fixed value, then shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            id_q <= ID_WORD;
        end else if (dr_path == PATH_ID) begin
            if (cap_dr)     id_q <= ID_WORD;
            else if (sh_dr) id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    // One next-value term per ring cell; the top cell takes TDI.
    for (genvar i = 0; i < BSR_W; i++) begin : g_cell
        if (i == BSR_W - 1) begin : g_top
            assign bsr_nxt[i] = bsr_cap ? ring_capture[i] : (bsr_sh ? tdi : bsr_q[i]);
        end else begin : g_mid
            assign bsr_nxt[i] = bsr_cap ? ring_capture[i] : (bsr_sh ? bsr_q[i+1] : bsr_q[i]);
        end
    end

    // Ring shift register.
    always_ff @(posedge tck) begin
        if (!trst_n) bsr_q <= '0;
        else         bsr_q <= bsr_nxt;
    end

    // Update latches: copy the ring on Update-DR under a ring instruction.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ring_preload <= '0;
        end else if (upd_dr && dr_path == PATH_BSR) begin
            ring_preload <= bsr_q;
        end
    end

    // Serial output of the selected path.
    always_comb begin
        unique case (dr_path)
            PATH_ID:  dr_lsb = id_q[0];
            PATH_BSR: dr_lsb = bsr_q[0];
            default:  dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/bscan_tap_top.sv
// Module bscan_tap_top
// Test access port of a memory device: controller, instruction path, decode, data paths and a TDO stage on the falling edge.
// Assumes the pads apply outputs_hiz and ext_drive. TDO is meant to be driven only while tdo_en is high.
module bscan_tap_top
    import bscan_pkg::*;
#(
    parameter int          BSR_W     = 109,
    parameter logic [2:0]  ID_REV    = 3'b000,
    parameter logic [16:0] ID_PART   = 17'h15A3C,
    parameter logic [10:0] ID_VENDOR = 11'h2B5
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] ring_capture,
    output logic             tdo,
    output logic             tdo_en,
    output logic [BSR_W-1:0] ring_preload,
    output logic             outputs_hiz,
    output logic             ext_drive
);

    tap_state_t      tap_state;
    logic [IR_W-1:0] ir_active;
    logic            ir_lsb;
    logic            dr_lsb;
    dr_path_t        dr_path;

    bscan_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (tap_state)
    );

    bscan_ir u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .state     (tap_state),
        .tdi       (tdi),
        .ir_lsb    (ir_lsb),
        .ir_active (ir_active)
    );

    bscan_decode u_dec (
        .ir_active   (ir_active),
        .dr_path     (dr_path),
        .outputs_hiz (outputs_hiz),
        .ext_drive   (ext_drive)
    );

    bscan_dr #(
        .BSR_W     (BSR_W),
        .ID_REV    (ID_REV),
        .ID_PART   (ID_PART),
        .ID_VENDOR (ID_VENDOR)
    ) u_dr (
        .tck          (tck),
        .trst_n       (trst_n),
        .state        (tap_state),
        .dr_path      (dr_path),
        .tdi          (tdi),
        .ring_capture (ring_capture),
        .dr_lsb       (dr_lsb),
        .ring_preload (ring_preload)
    );

    // Output stage on the falling edge: bit 0 of the shifting register, enabled only in shift states.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);
            tdo    <= (tap_state == ST_SH_IR) ? ir_lsb : dr_lsb;
        end
    end

endmodule

// File: rtl/bscan_tap_chk.sv
// Module bscan_tap_chk
// Protocol checker attached to bscan_tap_top. It only observes the design.
module bscan_tap_chk
    import bscan_pkg::*;
#(
    parameter int BSR_W = 109
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input tap_state_t       fsm_state,
    input logic [IR_W-1:0]  ir_active,
    input dr_path_t         dr_path,
    input logic             outputs_hiz,
    input logic             ext_drive,
    input logic             tdo_en,
    input logic [BSR_W-1:0] ring_preload
);

    logic [2:0] tms_run;

    // Counts consecutive TMS-high edges, saturating at 7.
    always_ff @(posedge tck) begin
        if (!trst_n)              tms_run <= '0;
        else if (!tms)            tms_run <= '0;
        else if (tms_run != 3'd7) tms_run <= tms_run + 3'd1;
    end

    a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run >= 3'd5) |-> (fsm_state == ST_TLR));

    a_r2_tlr_loads_idcode: assert property (@(posedge tck) disable iff (!trst_n)
        (fsm_state == ST_TLR) |=> (ir_active == OP_IDCODE && !outputs_hiz && !ext_drive));

    a_r3_hiz_rises_on_update: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(outputs_hiz) |-> ($past(fsm_state) == ST_UPD_IR));

    a_r6_reserved_safe: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_active == 3'b011 || ir_active == 3'b101 || ir_active == 3'b110)
            |-> (!outputs_hiz && !ext_drive && dr_path == PATH_BYP));

    a_r10_tdo_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (fsm_state == ST_SH_IR || fsm_state == ST_SH_DR));

    a_r11_preload_holds: assert property (@(posedge tck) disable iff (!trst_n)
        (fsm_state != ST_UPD_DR || dr_path != PATH_BSR) |=> $stable(ring_preload));

endmodule

bind bscan_tap_top bscan_tap_chk #(.BSR_W(BSR_W)) chk_i (
    .tck          (tck),
    .trst_n       (trst_n),
    .tms          (tms),
    .fsm_state    (tap_state),
    .ir_active    (ir_active),
    .dr_path      (dr_path),
    .outputs_hiz  (outputs_hiz),
    .ext_drive    (ext_drive),
    .tdo_en       (tdo_en),
    .ring_preload (ring_preload)
);

// File: tb/bscan_tap_top_tb_top.sv
// Scoreboard bench: the driver queues the expected serial words and a monitor compares them with what TDO produced.
module bscan_tap_top_tb_top;

    localparam int BW = 109;
    localparam logic [31:0] EXP_ID = {3'b000, 17'h15A3C, 11'h2B5, 1'b1};

    typedef struct {
        logic [BW-1:0] val;
        string         tag;
    } item_t;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BW-1:0] ring_cap = '0;
    logic          tdo, tdo_en, outputs_hiz, ext_drive;
    logic [BW-1:0] ring_preload;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 0;
    logic  pos_tdo;
    logic  mid_hiz;
    item_t exp_q[$];
    item_t act_q[$];
    event  got_act;

    always #4 tck = ~tck;

    bscan_tap_top dut_i (
        .tck          (tck),
        .trst_n       (trst_n),
        .tms          (tms),
        .tdi          (tdi),
        .ring_capture (ring_cap),
        .tdo          (tdo),
        .tdo_en       (tdo_en),
        .ring_preload (ring_preload),
        .outputs_hiz  (outputs_hiz),
        .ext_drive    (ext_drive)
    );

    task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop produced words and compare them with the queued expectations.
    initial begin
        forever begin
            @(got_act);
            while (act_q.size() > 0) begin
                item_t a, e;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    check({a.tag, " unexpected word"}, a.val, ~a.val);
                end else begin
                    e = exp_q.pop_front();
                    check(e.tag, a.val, e.val);
                end
            end
        end
    end

    // One TCK cycle; returns just after the falling edge.
    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        #1 pos_tdo = tdo;
        @(negedge tck);
        #1;
    endtask

    // Shift n bits from the current shift state. The last bit leaves through Exit1.
    task automatic shift_bits(input int n, input logic [BW-1:0] din, input string tag,
                              output logic [BW-1:0] dout);
        logic en_ok;
        logic edge_ok;
        dout    = '0;
        en_ok   = 1'b1;
        edge_ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic b;
            b = tdo;
            dout[i] = b;
            if (tdo_en !== 1'b1) en_ok = 1'b0;
            tick(i == n - 1, din[i]);
            if (pos_tdo !== b) edge_ok = 1'b0;
        end
        check({tag, " R10 tdo_en high in shift"}, BW'(en_ok), BW'(1));
        check({tag, " R10 tdo held across rising edge"}, BW'(edge_ok), BW'(1));
    endtask

    // Load an opcode from Run-Test-Idle and return to Run-Test-Idle.
    task automatic load_ir(input logic [2:0] op);
        item_t e, a;
        logic [BW-1:0] got;
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        got = '0;
        for (int i = 0; i < 3; i++) begin
            got[i] = tdo;
            if (i == 2) mid_hiz = outputs_hiz;
            tick(i == 2, op[i]);
        end
        e.val = BW'(3'b001); e.tag = "R3 capture-IR pattern";
        exp_q.push_back(e);
        a.val = got; a.tag = "ir";
        act_q.push_back(a); ->got_act;
        tick(1, 0); tick(0, 0);
    endtask

    // Scan n bits through the selected data path from Run-Test-Idle and back.
    task automatic scan_dr(input int n, input logic [BW-1:0] din, input logic [BW-1:0] exp,
                           input string tag);
        item_t e, a;
        logic [BW-1:0] got;
        tick(1, 0); tick(0, 0); tick(0, 0);
        e.val = exp; e.tag = tag;
        exp_q.push_back(e);
        shift_bits(n, din, tag, got);
        a.val = got; a.tag = tag;
        act_q.push_back(a); ->got_act;
        tick(1, 0); tick(0, 0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge tck);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    // Driver: stimulus sequence.
    initial begin
        logic [BW-1:0] pat;
        for (int i = 0; i < BW; i++) ring_cap[i] = ((i * 7 + 3) % 5) < 2;
        repeat (3) @(negedge tck);
        #1 trst_n = 1'b1;
        tick(1, 0);
        check("R2 reset hiz low", BW'(outputs_hiz), BW'(0));
        check("R2 reset ext_drive low", BW'(ext_drive), BW'(0));
        check("R11 reset preload zero", ring_preload, '0);
        tick(0, 0);
        check("R10 tdo_en low in idle", BW'(tdo_en), BW'(0));

        scan_dr(32, '0, BW'(EXP_ID), "R2 R4 default instruction reads ID");

        load_ir(3'b111);
        scan_dr(8, BW'(8'hB5), BW'(8'h6A), "R5 bypass one-cycle delay");
        check("R5 bypass leaves preload", ring_preload, '0);

        for (int k = 0; k < 3; k++) begin
            logic [2:0] r;
            r = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
            load_ir(r);
            check("R6 reserved hiz low", BW'(outputs_hiz), BW'(0));
            check("R6 reserved ext_drive low", BW'(ext_drive), BW'(0));
            scan_dr(8, BW'(8'h3C), BW'(8'h78), "R6 reserved acts as bypass");
        end

        load_ir(3'b010);
        check("R7 sample-z raises hiz", BW'(outputs_hiz), BW'(1));
        check("R7 sample-z ext_drive low", BW'(ext_drive), BW'(0));
        scan_dr(BW, '0, ring_cap, "R7 sample-z captures ring");

        pat = '0;
        for (int i = 0; i < BW; i++) pat[i] = (i % 3) == 1;
        load_ir(3'b100);
        check("R3 hiz held during Shift-IR", BW'(mid_hiz), BW'(1));
        check("R8 preload drops hiz after update", BW'(outputs_hiz), BW'(0));
        scan_dr(BW, pat, ring_cap, "R8 preload captures ring");
        check("R8 R11 update-DR loads preload", ring_preload, pat);

        ring_cap = ~ring_cap;
        load_ir(3'b000);
        check("R9 extest raises ext_drive", BW'(ext_drive), BW'(1));
        check("R9 extest hiz low", BW'(outputs_hiz), BW'(0));
        scan_dr(BW, ~pat, ring_cap, "R9 extest captures ring");
        check("R9 extest update loads preload", ring_preload, ~pat);

        load_ir(3'b001);
        scan_dr(32, '0, BW'(EXP_ID), "R4 IDCODE word");
        check("R11 IDCODE leaves preload", ring_preload, ~pat);

        load_ir(3'b010);
        for (int i = 0; i < 5; i++) tick(1, 0);
        check("R1 R2 five TMS-high clear hiz", BW'(outputs_hiz), BW'(0));
        tick(0, 0);
        scan_dr(32, '0, BW'(EXP_ID), "R1 TMS reset restores IDCODE");

        load_ir(3'b010);
        trst_n = 1'b0;
        tick(1, 0);
        trst_n = 1'b1;
        check("R2 trst_n clears hiz", BW'(outputs_hiz), BW'(0));
        tick(0, 0);

        repeat (2) tick(0, 0);
        check("scoreboard drained", BW'(exp_q.size()), BW'(0));
        finish_run();
    end

endmodule